// File: doc/BRIEF.md
# Programmable 16-bit Event Counter Channel

This block is a single 16-bit counter channel with three registers behind a small register port: a count, a mode word and a target. On every clock edge the counter may advance by one. What makes it advance is the tick source picked by the mode word. On the line-timed variant the source is either the system clock or a pulse on `alt_tick`. On the divided-clock variant it is either the system clock or one pulse per eight clocks. The counter wraps at the target or at 0x10000. Each wrap raises sticky status flags and can raise a one-cycle interrupt pulse. That pulse fires on every event in repeat mode, or only on the first event after a mode write in one-shot mode.

A sync-enable bit ties the counter to the `blank` input. On the line-timed variant this can pause counting while `blank` is high, or clear the count when blanking ends. On the divided-clock variant some sync settings stop the counter completely. The parameter `KIND` picks the variant: 0 is line-timed and 1 is divided-clock. The register port is plain control access with no handshake. A write takes effect at the clock edge. Read data is combinational from `reg_sel`. A read strobe matters only for its clearing side effect on the mode word.

Top module: `ctr16_channel`

## Requirements
- R1: `reg_sel` picks the register: 0 is the count, 1 is the mode word and 2 is the target. Select 3 reads zero, and writes to it change nothing. After reset all three registers read zero and `irq` is low.
- R2: When no write, sync clear or sync hold applies, the count grows by one on each tick. A tick is every clock, except on the line-timed variant with mode bit 8 set, where a tick is each clock edge at which `alt_tick` is high.
- R3: When mode bit 3 is set, a tick that would make the count equal the target loads zero instead. This is a target event. When bit 3 is clear, the count passes the target (still a target event) and continues. A tick at 0xFFFF loads zero and is an overflow event.
- R4: Mode bit 4 arms the interrupt for target events, and bit 5 arms it for overflow events. `irq` is high for the one cycle that follows the clock edge of an armed event.
- R5: With mode bit 6 set, every armed event pulses `irq`. With bit 6 clear, only the first armed event after a mode write pulses it.
- R6: Mode bit 11 records a target event and bit 12 records an overflow event. A read strobe on select 1 returns the flags and then clears bits 11 and 12, unless an event sets a flag in that same cycle. Bit 10 is set by any event and is cleared only by a mode write.
- R7: A mode write stores bits 9:0, clears bits 10 to 12, sets the count to zero, re-arms one-shot mode and restarts the divide-by-eight prescaler. Bits 15:13 always read zero.
- R8: A target write leaves the count running undisturbed. A count write loads the written value, and that load takes the place of a tick in the same cycle.
- R9: On the line-timed variant with mode bit 0 set, sync field bits 2:1 decide the effect. A value of 0 holds the count while `blank` is high. A value of 1 or 2 clears the count in the cycle where `blank` falls. A value of 3 has no effect.
- R10: On the divided-clock variant, mode bit 9 makes the tick the eighth clock after the last mode write, then every eighth clock. Mode bit 8 has no effect on this variant.
- R11: On the divided-clock variant with mode bit 0 set, sync field values 0 and 3 stop the counter. Values 1 and 2 have no effect, and `blank` never matters.
- R12: A target of zero never produces a target event. With bit 3 set, the counter then runs to 0xFFFF and overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select (0 count, 1 mode, 2 target) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe; clears sticky flags when select is 1 |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the selected register |
| alt_tick | input | 1 | Alternate tick pulse (line-timed variant) |
| blank | input | 1 | Blanking input for sync modes |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Both variants receive the same stimulus and are compared every cycle against a behavioural model. The counting patterns are a free run, a wrap at the target with repeat and one-shot interrupts, and a preload near 0xFFFF with targets of 5 and 0. Together these separate target events from overflow events and separate the two interrupt modes. Back-to-back mode reads across target hits show that a flag set in the same cycle survives the clear. An `alt_tick` pulse train and the divide-by-eight source check that the count moves only on the selected tick. `blank` pulses under every sync field value separate hold, clear-on-fall, stop and no effect between the two variants.

// File: rtl/ctr16_pkg.sv
package ctr16_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int CTRL_W    = 10;
  localparam int B_SYNC    = 0;
  localparam int B_RST_TGT = 3;
  localparam int B_IRQ_TGT = 4;
  localparam int B_IRQ_OVF = 5;
  localparam int B_IRQ_RPT = 6;
  localparam int B_SRC_ALT = 8;
  localparam int B_SRC_DIV = 9;
endpackage

// File: rtl/ctr16_tick.sv
module ctr16_tick #(
  parameter int KIND = 0,
  parameter int DIV  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       sync_en,
  input  logic [1:0] sync_sel,
  input  logic       alt_sel,
  input  logic       div_sel,
  input  logic       alt_tick,
  input  logic       blank,
  output logic       adv,
  output logic       sync_clr
);
  localparam bit IS_DIV = (KIND != 0);
  localparam int PW     = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] presc;
  logic          div_tick;
  logic          blank_q;
  logic          raw;
  logic          halt;

  assign div_tick = (presc == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= '0;
      blank_q <= 1'b0;
    end else begin
      blank_q <= blank;
      if (mode_wr || div_tick) presc <= '0;
      else                     presc <= presc + 1'b1;
    end
  end

  always_comb begin
    if (IS_DIV) begin
      raw  = div_sel ? div_tick : 1'b1;
      halt = sync_en && (sync_sel == 2'd0 || sync_sel == 2'd3);
    end else begin
      raw  = alt_sel ? alt_tick : 1'b1;
      halt = sync_en && (sync_sel == 2'd0) && blank;
    end
  end

  assign adv      = raw && !halt;
  assign sync_clr = !IS_DIV && sync_en && (sync_sel == 2'd1 || sync_sel == 2'd2)
                    && blank_q && !blank;
endmodule

// File: rtl/ctr16_core.sv
module ctr16_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         sync_clr,
  input  logic         mode_wr,
  input  logic         cnt_wr,
  input  logic         tgt_wr,
  input  logic [W-1:0] wdata,
  input  logic         rst_at_tgt,
  output logic [W-1:0] count,
  output logic [W-1:0] target,
  output logic         hit_tgt,
  output logic         hit_ovf
);
  logic [W:0] nxt;
  logic       step;

  assign nxt     = {1'b0, count} + 1'b1;
  assign step    = adv && !mode_wr && !cnt_wr && !sync_clr;
  assign hit_tgt = step && (nxt == {1'b0, target});
  assign hit_ovf = step && nxt[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      target <= '0;
    end else begin
      if (tgt_wr) target <= wdata;
      if (mode_wr)                     count <= '0;
      else if (cnt_wr)                 count <= wdata;
      else if (sync_clr)               count <= '0;
      else if (hit_tgt && rst_at_tgt)  count <= '0;
      else if (step)                   count <= nxt[W-1:0];
    end
  end
endmodule

// File: rtl/ctr16_flags.sv
module ctr16_flags
  import ctr16_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic          mode_rd,
  input  logic [CW-1:0] wr_ctrl,
  input  logic          hit_tgt,
  input  logic          hit_ovf,
  output logic [W-1:0]  mode_q,
  output logic          irq
);
  localparam int PAD = W - CW - 3;

  logic [CW-1:0] ctrl;
  logic          any_ev, f_tgt, f_ovf, fired;
  logic          want, fire;

  assign want = (hit_tgt && ctrl[B_IRQ_TGT]) || (hit_ovf && ctrl[B_IRQ_OVF]);
  assign fire = want && (ctrl[B_IRQ_RPT] || !fired);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      any_ev <= 1'b0;
      f_tgt  <= 1'b0;
      f_ovf  <= 1'b0;
      fired  <= 1'b0;
      irq    <= 1'b0;
    end else if (mode_wr) begin
      ctrl   <= wr_ctrl;
      any_ev <= 1'b0;
      f_tgt  <= 1'b0;
      f_ovf  <= 1'b0;
      fired  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) fired <= 1'b1;
      if (hit_tgt || hit_ovf) any_ev <= 1'b1;
      if (hit_tgt)      f_tgt <= 1'b1;
      else if (mode_rd) f_tgt <= 1'b0;
      if (hit_ovf)      f_ovf <= 1'b1;
      else if (mode_rd) f_ovf <= 1'b0;
    end
  end

  assign mode_q = {{PAD{1'b0}}, f_ovf, f_tgt, any_ev, ctrl};
endmodule

// File: rtl/ctr16_channel.sv
module ctr16_channel #(
  parameter int CNT_W = 16,
  parameter int KIND  = 0,
  parameter int DIV   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             alt_tick,
  input  logic             blank,
  output logic             irq
);
  import ctr16_pkg::*;

  reg_sel_e         sel;
  logic             mode_wr, mode_rd, cnt_wr, tgt_wr;
  logic             adv, sync_clr, hit_tgt, hit_ovf;
  logic [CNT_W-1:0] count, target, mode_q;

  assign sel     = reg_sel_e'(reg_sel);
  assign mode_wr = reg_wr && (sel == SEL_MODE);
  assign cnt_wr  = reg_wr && (sel == SEL_COUNT);
  assign tgt_wr  = reg_wr && (sel == SEL_TARGET);
  assign mode_rd = reg_rd && (sel == SEL_MODE);

  ctr16_tick #(.KIND(KIND), .DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr),
    .sync_en(mode_q[B_SYNC]), .sync_sel(mode_q[2:1]),
    .alt_sel(mode_q[B_SRC_ALT]), .div_sel(mode_q[B_SRC_DIV]),
    .alt_tick(alt_tick), .blank(blank),
    .adv(adv), .sync_clr(sync_clr)
  );

  ctr16_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sync_clr(sync_clr),
    .mode_wr(mode_wr), .cnt_wr(cnt_wr), .tgt_wr(tgt_wr), .wdata(reg_wdata),
    .rst_at_tgt(mode_q[B_RST_TGT]),
    .count(count), .target(target), .hit_tgt(hit_tgt), .hit_ovf(hit_ovf)
  );

  ctr16_flags #(.W(CNT_W), .CW(CTRL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_rd(mode_rd),
    .wr_ctrl(reg_wdata[CTRL_W-1:0]), .hit_tgt(hit_tgt), .hit_ovf(hit_ovf),
    .mode_q(mode_q), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_COUNT:  reg_rdata = count;
      SEL_MODE:   reg_rdata = mode_q;
      SEL_TARGET: reg_rdata = target;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctr16_channel_sva.sv
module ctr16_channel_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_sel,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] mode_q,
  input logic             adv,
  input logic             sync_clr,
  input logic             hit_tgt,
  input logic             hit_ovf
);
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((hit_tgt && mode_q[4]) || (hit_ovf && mode_q[5]))); // R4

  AST_ONE_SHOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !mode_q[6]) |=> !irq); // R5

  AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == 2'd1 && !reg_wr && !hit_tgt && !hit_ovf) |=> (mode_q[12:11] == 2'b00)); // R6

  AST_MODE_WRITE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1) |=> (count == '0 && mode_q[12:10] == 3'b000 && !irq)); // R7

  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !reg_wr && !sync_clr) |=> $stable(count)); // R2

  AST_TARGET_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && !adv && !sync_clr) |=> $stable(count)); // R8
endmodule

bind ctr16_channel ctr16_channel_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .irq(irq), .count(count), .mode_q(mode_q), .adv(adv), .sync_clr(sync_clr),
  .hit_tgt(hit_tgt), .hit_ovf(hit_ovf)
);

// File: tb/ctr16_channel_test.sv
module ctr16_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic        alt_tick = 1'b0;
  logic        blank = 1'b0;
  logic [15:0] rdata [2];
  logic        irq [2];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string req = "R1";

  always #5 clk = ~clk;

  ctr16_channel #(.KIND(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rdata[0]), .alt_tick(alt_tick), .blank(blank),
    .irq(irq[0])
  );

  ctr16_channel #(.KIND(1)) uut_div (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rdata[1]), .alt_tick(alt_tick), .blank(blank),
    .irq(irq[1])
  );

  // Behavioural reference: one state set per variant (0 line-timed, 1 divided)
  int m_ctrl[2], m_cnt[2], m_tgt[2], m_presc[2];
  bit m_any[2], m_ft[2], m_fo[2], m_fired[2], m_irq[2], m_bq[2];

  function automatic int exp_rd(input int k);
    case (reg_sel)
      2'd0: return m_cnt[k];
      2'd1: return (int'(m_fo[k]) << 12) | (int'(m_ft[k]) << 11) | (int'(m_any[k]) << 10) | m_ctrl[k];
      2'd2: return m_tgt[k];
      default: return 0;
    endcase
  endfunction

  task automatic m_step(input int k);
    bit wrm, wrc, wrt, rdm, tick, hold, sclr, et, eo;
    int n, ss;
    wrm = reg_wr && reg_sel == 2'd1;
    wrc = reg_wr && reg_sel == 2'd0;
    wrt = reg_wr && reg_sel == 2'd2;
    rdm = reg_rd && reg_sel == 2'd1;
    ss  = (m_ctrl[k] >> 1) & 3;
    if (k == 0) begin
      tick = m_ctrl[k][8] ? alt_tick : 1'b1;
      hold = m_ctrl[k][0] && ss == 0 && blank;
      sclr = m_ctrl[k][0] && (ss == 1 || ss == 2) && m_bq[k] && !blank;
    end else begin
      tick = m_ctrl[k][9] ? (m_presc[k] == 7) : 1'b1;
      hold = m_ctrl[k][0] && (ss == 0 || ss == 3);
      sclr = 1'b0;
    end
    et = 0; eo = 0;
    if (wrt) m_tgt[k] = reg_wdata;
    if (wrm) begin
      m_ctrl[k] = reg_wdata & 16'h03FF;
      m_any[k] = 0; m_ft[k] = 0; m_fo[k] = 0; m_fired[k] = 0; m_irq[k] = 0;
      m_cnt[k] = 0; m_presc[k] = 0;
    end else begin
      if (wrc) m_cnt[k] = reg_wdata;
      else if (sclr) m_cnt[k] = 0;
      else if (tick && !hold) begin
        n = m_cnt[k] + 1;
        if (n == (wrt ? m_tgt_old : m_tgt[k])) begin
          et = 1;
          m_cnt[k] = m_ctrl[k][3] ? 0 : n;
        end else if (n == 65536) begin
          eo = 1; m_cnt[k] = 0;
        end else m_cnt[k] = n;
      end
      if (rdm) begin m_ft[k] = 0; m_fo[k] = 0; end
      if (et) begin m_ft[k] = 1; m_any[k] = 1; end
      if (eo) begin m_fo[k] = 1; m_any[k] = 1; end
      m_irq[k] = 0;
      if (((et && m_ctrl[k][4]) || (eo && m_ctrl[k][5])) && (m_ctrl[k][6] || !m_fired[k])) begin
        m_irq[k] = 1; m_fired[k] = 1;
      end
      m_presc[k] = (m_presc[k] == 7) ? 0 : m_presc[k] + 1;
    end
    m_bq[k] = blank;
  endtask

  int m_tgt_old;

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_ctrl[k] = 0; m_cnt[k] = 0; m_tgt[k] = 0; m_presc[k] = 0;
        m_any[k] = 0; m_ft[k] = 0; m_fo[k] = 0; m_fired[k] = 0; m_irq[k] = 0; m_bq[k] = 0;
      end else begin
        m_tgt_old = m_tgt[k];
        m_step(k);
      end
    end
  end

  // Compare both variants against the model away from the active edge
  always @(negedge clk) begin
    cycles++;
    for (int k = 0; k < 2; k++) begin
      checks++;
      if (int'(rdata[k]) != exp_rd(k)) begin
        errors++;
        $display("FAIL %s kind%0d sel%0d rdata: actual %h expected %h", req, k, reg_sel, rdata[k], exp_rd(k));
      end
      checks++;
      if (irq[k] != m_irq[k]) begin
        errors++;
        $display("FAIL %s kind%0d irq: actual %0d expected %0d", req, k, irq[k], m_irq[k]);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic op(input logic [1:0] s, input logic w, input logic r, input logic [15:0] d);
    reg_sel = s; reg_wr = w; reg_rd = r; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 16'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic blank_pulse(input int hi, input int lo);
    blank = 1'b1; idle(hi);
    blank = 1'b0; idle(lo);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: register map, select 3 inert, reset values
    req = "R1";
    op(2'd3, 1'b1, 1'b0, 16'h1234);
    op(2'd3, 1'b0, 1'b0, 16'h0);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    op(2'd2, 1'b0, 1'b0, 16'h0);
    // R2: free run on the system clock
    req = "R2";
    op(2'd1, 1'b1, 1'b0, 16'h0000);
    idle(10);
    // R3 R4 R5: wrap at target with repeat interrupt
    req = "R3";
    op(2'd2, 1'b1, 1'b0, 16'd5);
    op(2'd1, 1'b1, 1'b0, 16'h0058);
    idle(20);
    req = "R5";
    op(2'd1, 1'b1, 1'b0, 16'h0018);
    idle(20);
    // R4: overflow interrupt, target passed without reset
    req = "R4";
    op(2'd1, 1'b1, 1'b0, 16'h0020);
    op(2'd0, 1'b1, 1'b0, 16'hFFFA);
    idle(14);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    // R12: target zero never matches
    req = "R12";
    op(2'd2, 1'b1, 1'b0, 16'd0);
    op(2'd1, 1'b1, 1'b0, 16'h0078);
    op(2'd0, 1'b1, 1'b0, 16'hFFFC);
    idle(8);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    // R6: mode read clears sticky bits, coinciding event wins
    req = "R6";
    op(2'd1, 1'b0, 1'b1, 16'h0);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    op(2'd2, 1'b1, 1'b0, 16'd3);
    op(2'd1, 1'b1, 1'b0, 16'h0008);
    idle(2);
    for (int i = 0; i < 8; i++) op(2'd1, 1'b0, 1'b1, 16'h0);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    // R7: mode write stores low bits only, top bits read zero
    req = "R7";
    op(2'd1, 1'b1, 1'b0, 16'hFFFF);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    idle(4);
    op(2'd1, 1'b1, 1'b0, 16'hE000);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    // R8: target write keeps count, count write loads
    req = "R8";
    op(2'd1, 1'b1, 1'b0, 16'h0000);
    idle(5);
    op(2'd2, 1'b1, 1'b0, 16'h0100);
    idle(3);
    op(2'd0, 1'b1, 1'b0, 16'h0040);
    idle(3);
    // R2: alternate tick pulses on the line-timed variant
    req = "R2";
    op(2'd1, 1'b1, 1'b0, 16'h0100);
    for (int i = 0; i < 12; i++) begin
      alt_tick = (i % 3 == 0);
      idle(1);
    end
    alt_tick = 1'b0;
    // R9 R11: every sync field value with blanking pulses
    req = "R9";
    op(2'd1, 1'b1, 1'b0, 16'h0001);
    idle(2); blank_pulse(5, 5);
    op(2'd1, 1'b1, 1'b0, 16'h0003);
    idle(4); blank_pulse(3, 4);
    op(2'd1, 1'b1, 1'b0, 16'h0005);
    idle(4); blank_pulse(3, 4);
    op(2'd1, 1'b1, 1'b0, 16'h0007);
    idle(4); blank_pulse(3, 4);
    // R10: divide-by-eight source, bit 8 ignored on the divided variant
    req = "R10";
    op(2'd1, 1'b1, 1'b0, 16'h0200);
    idle(30);
    op(2'd1, 1'b1, 1'b0, 16'h0300);
    idle(5);
    op(2'd1, 1'b1, 1'b0, 16'h0300);
    idle(20);
    op(2'd1, 1'b1, 1'b0, 16'h0100);
    idle(6);
    req = "R11";
    op(2'd1, 1'b1, 1'b0, 16'h0201);
    idle(12); blank_pulse(2, 2);
    op(2'd1, 1'b1, 1'b0, 16'h0207);
    idle(12);
    op(2'd1, 1'b1, 1'b0, 16'h0203);
    idle(20); blank_pulse(2, 3);
    op(2'd1, 1'b1, 1'b0, 16'h0205);
    idle(20);
    op(2'd1, 1'b0, 1'b0, 16'h0);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule